// File: doc/BRIEF.md
# Multi-format audio DAC serializer

This block turns parallel stereo PCM samples into the serial stream a DAC expects. It runs on the master clock and divides it by an even ratio to make the bit clock. Three framings are available. Two are split-channel formats, where left and right leave at the same time on their own lines: a 16-bit offset-binary format sampled on the falling bit-clock edge, and a 24-bit two's-complement format sampled on the rising edge. The third is standard I2S, where both channels share one line under word select.

Samples arrive as 24-bit two's-complement left/right pairs over a valid/ready handshake. The block takes a new pair only at a frame boundary and repeats the previous pair when none is offered. The format code is read during reset and again at each frame boundary. A new code restarts the frame counter at slot 0. In the split-channel formats the block also drives complemented copies of both data lines, so a balanced DAC pair can be fed, and a latch-enable pulse that closes each word. The master clock is passed straight through.

Top module: `pcm_dac_serializer`

## Requirements
- R1: `bck_o` has a period of DIV master-clock cycles. It is low for the first DIV/2 cycles of each bit period and high for the rest.
- R2: `mck_o` follows `clk_i`.
- R3: Format codes on `mode_i` are 0 = split 16-bit offset binary, 1 = I2S, 2 = split 24-bit, and 3 behaves as I2S. The code is captured while `rst_i` is high and at each frame boundary, and nowhere else. Each frame starts at slot 0. A 16-bit split frame lasts 32 bit periods, so after reset in that format the first `ready_o` comes 32*DIV-1 cycles after the first clock with reset low.
- R4: Split 16-bit frames have 32 slots. Slots 0-15 are 0. Slots 16-31 carry input bits 23..8, MSB first, with bit 23 inverted (offset binary). Left goes on `dl_o` and right on `dr_o`. The lines change only as `bck_o` rises, so they are stable at its falling edge.
- R5: Split 24-bit frames have 32 slots. Slots 0-7 are 0. Slots 8-31 carry input bits 23..0, MSB first, in two's complement. Left goes on `dl_o` and right on `dr_o`. The lines change only as `bck_o` falls, so they are stable at its rising edge.
- R6: I2S frames have 64 slots. `lews_o` is 0 in slots 0-31 (left) and 1 in slots 32-63 (right). The data goes on `dr_o`: the 24-bit word in slots 1-24 of each half, MSB first, and 0 elsewhere. `dl_o`, `dln_o` and `drn_o` stay 0. Data and word select change only as `bck_o` falls.
- R7: In both split formats, `dln_o` is the complement of `dl_o` and `drn_o` is the complement of `dr_o`.
- R8: In both split formats, `lews_o` is 1 during slot 0 only. That is the one bit period right after the LSB in slot 31.
- R9: `ready_o` is high for exactly one cycle, the last cycle of a frame. A pair is taken only when `valid_i` and `ready_o` are both high, and `valid_i` at any other time has no effect.
- R10: When no pair is taken at a boundary, the next frame repeats the last pair.
- R11: While reset is applied, every serial output and `ready_o` are 0 and the held pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Format code |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Frame boundary, pair taken this cycle if valid |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| mck_o | output | 1 | Forwarded master clock |
| bck_o | output | 1 | Bit clock |
| lews_o | output | 1 | Word select (I2S) or latch enable (split) |
| dl_o | output | 1 | Left data line |
| dln_o | output | 1 | Complemented left data line |
| dr_o | output | 1 | Right data line, or the shared I2S line |
| drn_o | output | 1 | Complemented right data line |

## Verification
A wrong slot count moves every captured bit and the latch or word-select edge. It shows at the ports within one frame, at most 64 bit periods. A wrong phase counter changes the bit-clock period or duty within DIV cycles. A data register updated on the wrong phase makes a line change at the DAC's sampling edge, which is visible in the first bit period. A sample register that loads off the boundary, or fails to hold, makes the next frame carry the wrong word.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;

    localparam int SMP_W     = 24;
    localparam int SLOT_BITS = 32;
    localparam int SIM_W     = 16;
    localparam int CNT_W     = 6;
    localparam int SPLIT_PAD = SLOT_BITS - SMP_W;
    localparam int SIM_PAD   = SLOT_BITS - SIM_W;

    typedef enum logic [1:0] {
        FMT_SIM16   = 2'd0,
        FMT_I2S     = 2'd1,
        FMT_SPLIT24 = 2'd2,
        FMT_RSVD    = 2'd3
    } fmt_e;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } pair_t;

    typedef struct packed {
        logic dl;
        logic dln;
        logic dr;
        logic drn;
        logic lews;
    } lines_t;

    function automatic fmt_e fmt_decode(input logic [1:0] code);
        case (code)
            2'd0:    return FMT_SIM16;
            2'd2:    return FMT_SPLIT24;
            default: return FMT_I2S;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] frame_last(input fmt_e f);
        return (f == FMT_I2S) ? CNT_W'(2*SLOT_BITS-1) : CNT_W'(SLOT_BITS-1);
    endfunction

    // The DAC samples on the falling bit-clock edge only in the 16-bit split format
    function automatic logic samples_on_fall(input fmt_e f);
        return f == FMT_SIM16;
    endfunction

    // Bit 'pos' of a word counted from its MSB (pos 0 = MSB)
    function automatic logic msb_pick(input logic [SMP_W-1:0] w, input int pos);
        logic [SMP_W-1:0] t;
        t = w << pos;
        return t[SMP_W-1];
    endfunction

    // Line levels for one slot of a frame
    function automatic lines_t slot_lines(input fmt_e f, input logic [CNT_W-1:0] cnt,
                                          input pair_t p);
        lines_t o;
        int idx;
        logic [SMP_W-1:0] lw;
        logic [SMP_W-1:0] rw;
        o   = '0;
        idx = int'(cnt[4:0]);
        case (f)
            FMT_SIM16: begin
                lw = {~p.left[SMP_W-1],  p.left[SMP_W-2:0]};
                rw = {~p.right[SMP_W-1], p.right[SMP_W-2:0]};
                o.lews = (idx == 0);
                if (idx >= SIM_PAD) begin
                    o.dl = msb_pick(lw, idx - SIM_PAD);
                    o.dr = msb_pick(rw, idx - SIM_PAD);
                end
            end
            FMT_SPLIT24: begin
                o.lews = (idx == 0);
                if (idx >= SPLIT_PAD) begin
                    o.dl = msb_pick(p.left,  idx - SPLIT_PAD);
                    o.dr = msb_pick(p.right, idx - SPLIT_PAD);
                end
            end
            default: begin
                o.lews = cnt[5];
                if (idx >= 1 && idx <= SMP_W)
                    o.dr = msb_pick(cnt[5] ? p.right : p.left, idx - 1);
            end
        endcase
        if (f != FMT_I2S) begin
            o.dln = ~o.dl;
            o.drn = ~o.dr;
        end
        return o;
    endfunction

endpackage

// File: rtl/pcm_ser_bclk.sv
module pcm_ser_bclk #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic bit_end_o,
    output logic mid_pre_o,
    output logic bck_o
);
    localparam int HALF = DIV / 2;
    localparam int PH_W = $clog2(DIV);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)          ph_q <= '0;
        else if (bit_end_o) ph_q <= '0;
        else                ph_q <= ph_q + PH_W'(1);
    end

    assign bit_end_o = (ph_q == PH_W'(DIV-1));
    assign mid_pre_o = (ph_q == PH_W'(HALF-1));
    assign bck_o     = (ph_q >= PH_W'(HALF));

    // R1: the bit clock rises only one cycle after the mid-period marker
    a_r1_rise_after_mid: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(bck_o) |-> $past(mid_pre_o));

endmodule

// File: rtl/pcm_ser_frame_ctl.sv
module pcm_ser_frame_ctl
    import pcm_ser_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [1:0]       mode_i,
    input  logic             valid_i,
    input  logic [SMP_W-1:0] left_i,
    input  logic [SMP_W-1:0] right_i,
    input  logic             bit_end_i,
    output logic             ready_o,
    output fmt_e             fmt_q_o,
    output fmt_e             fmt_nx_o,
    output logic [CNT_W-1:0] cnt_nx_o,
    output pair_t            pair_nx_o
);
    logic [CNT_W-1:0] cnt_q;
    fmt_e             fmt_q;
    pair_t            pair_q;
    logic             frame_end;

    assign frame_end = bit_end_i && (cnt_q == frame_last(fmt_q));
    assign ready_o   = frame_end;

    always_comb begin
        cnt_nx_o  = cnt_q;
        fmt_nx_o  = fmt_q;
        pair_nx_o = pair_q;
        if (bit_end_i)
            cnt_nx_o = frame_end ? '0 : cnt_q + CNT_W'(1);
        if (frame_end) begin
            fmt_nx_o = fmt_decode(mode_i);
            if (valid_i)
                pair_nx_o = '{left: left_i, right: right_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            fmt_q  <= fmt_decode(mode_i);
            pair_q <= '0;
        end else begin
            cnt_q  <= cnt_nx_o;
            fmt_q  <= fmt_nx_o;
            pair_q <= pair_nx_o;
        end
    end

    assign fmt_q_o = fmt_q;

    // R10: the held pair changes only after a boundary cycle
    a_r10_pair_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |=> $stable(pair_q));
    // R3: the active format changes only after a boundary cycle
    a_r3_fmt_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        !ready_o |=> $stable(fmt_q));

endmodule

// File: rtl/pcm_ser_line_drv.sv
module pcm_ser_line_drv
    import pcm_ser_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             bit_end_i,
    input  logic             mid_pre_i,
    input  fmt_e             fmt_nx_i,
    input  logic [CNT_W-1:0] cnt_nx_i,
    input  pair_t            pair_nx_i,
    output lines_t           lines_o
);
    logic   upd;
    lines_t lines_q;

    // Lines move on the bit-clock edge opposite the DAC's sampling edge
    assign upd = samples_on_fall(fmt_nx_i) ? mid_pre_i : bit_end_i;

    always_ff @(posedge clk_i) begin
        if (rst_i)    lines_q <= '0;
        else if (upd) lines_q <= slot_lines(fmt_nx_i, cnt_nx_i, pair_nx_i);
    end

    assign lines_o = lines_q;

endmodule

// File: rtl/pcm_dac_serializer.sv
module pcm_dac_serializer
    import pcm_ser_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [1:0]  mode_i,
    input  logic        valid_i,
    output logic        ready_o,
    input  logic [23:0] left_i,
    input  logic [23:0] right_i,
    output logic        mck_o,
    output logic        bck_o,
    output logic        lews_o,
    output logic        dl_o,
    output logic        dln_o,
    output logic        dr_o,
    output logic        drn_o
);
    logic             bit_end;
    logic             mid_pre;
    fmt_e             fmt_q;
    fmt_e             fmt_nx;
    logic [CNT_W-1:0] cnt_nx;
    pair_t            pair_nx;
    lines_t           lines;

    pcm_ser_bclk #(.DIV(DIV)) u_bclk (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bit_end_o (bit_end),
        .mid_pre_o (mid_pre),
        .bck_o     (bck_o)
    );

    pcm_ser_frame_ctl u_frame (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .mode_i    (mode_i),
        .valid_i   (valid_i),
        .left_i    (left_i),
        .right_i   (right_i),
        .bit_end_i (bit_end),
        .ready_o   (ready_o),
        .fmt_q_o   (fmt_q),
        .fmt_nx_o  (fmt_nx),
        .cnt_nx_o  (cnt_nx),
        .pair_nx_o (pair_nx)
    );

    pcm_ser_line_drv u_lines (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .bit_end_i (bit_end),
        .mid_pre_i (mid_pre),
        .fmt_nx_i  (fmt_nx),
        .cnt_nx_i  (cnt_nx),
        .pair_nx_i (pair_nx),
        .lines_o   (lines)
    );

    assign mck_o  = clk_i;
    assign dl_o   = lines.dl;
    assign dln_o  = lines.dln;
    assign dr_o   = lines.dr;
    assign drn_o  = lines.drn;
    assign lews_o = lines.lews;

    // R9: the boundary falls in the last (high) cycle of a bit period
    a_r9_ready_bck_high: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> bck_o);
    // R5, R6: in rising-sampled formats, lines hold across the rising edge
    a_r5_stable_at_rise: assert property (@(posedge clk_i) disable iff (rst_i)
        (fmt_q != FMT_SIM16 && $stable(fmt_q) && $rose(bck_o))
        |-> ($stable(dr_o) && $stable(dl_o) && $stable(lews_o)));
    // R4: in the 16-bit split format, lines hold across the falling edge
    a_r4_stable_at_fall: assert property (@(posedge clk_i) disable iff (rst_i)
        (fmt_q == FMT_SIM16 && $stable(fmt_q) && $fell(bck_o))
        |-> ($stable(dr_o) && $stable(dl_o) && $stable(lews_o)));

endmodule

// File: tb/pcm_dac_serializer_tb.sv
module pcm_dac_serializer_tb;

    localparam int DIV = 4;
    localparam int NV  = 6;
    // {mode, left, right}
    localparam logic [49:0] TABLE [NV] = '{
        {2'd0, 24'h123456, 24'hFEDCBA},
        {2'd2, 24'h800001, 24'h7FFFFE},
        {2'd1, 24'hA5A5A5, 24'h3C3C3C},
        {2'd0, 24'h800000, 24'h7FFF00},
        {2'd3, 24'h000001, 24'hFFFFFF},
        {2'd2, 24'h000000, 24'hFFFFFF}
    };

    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic [1:0]  mode_i = 2'd0;
    logic        valid_i = 1'b0;
    logic [23:0] left_i = '0;
    logic [23:0] right_i = '0;
    logic ready_o, mck_o, bck_o, lews_o, dl_o, dln_o, dr_o, drn_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pcm_dac_serializer #(.DIV(DIV)) u_dut (
        .clk_i(clk), .rst_i(rst_i), .mode_i(mode_i), .valid_i(valid_i),
        .ready_o(ready_o), .left_i(left_i), .right_i(right_i), .mck_o(mck_o),
        .bck_o(bck_o), .lews_o(lews_o), .dl_o(dl_o), .dln_o(dln_o),
        .dr_o(dr_o), .drn_o(drn_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // 0 = split16, 1 = I2S, 2 = split24
    function automatic int kind(input logic [1:0] c);
        return (c == 2'd0) ? 0 : (c == 2'd2) ? 2 : 1;
    endfunction

    task automatic run_frame(input logic [1:0] code, input logic [23:0] l,
                             input logic [23:0] r, input logic use_valid,
                             output logic [63:0] vdl, output logic [63:0] vdln,
                             output logic [63:0] vdr, output logic [63:0] vdrn,
                             output logic [63:0] vle);
        int  n;
        int  k;
        logic prev;
        logic want;
        while (ready_o) @(negedge clk);
        mode_i = code; left_i = l; right_i = r; valid_i = use_valid;
        do @(negedge clk); while (!ready_o);
        @(negedge clk);
        valid_i = 1'b0;
        n    = (kind(code) == 1) ? 64 : 32;
        want = (kind(code) != 0);
        vdl = '0; vdln = '0; vdr = '0; vdrn = '0; vle = '0;
        prev = bck_o;
        k = 0;
        while (k < n) begin
            @(negedge clk);
            if (bck_o != prev && bck_o == want) begin
                vdl[n-1-k] = dl_o;  vdln[n-1-k] = dln_o;
                vdr[n-1-k] = dr_o;  vdrn[n-1-k] = drn_o;
                vle[n-1-k] = lews_o;
                k++;
            end
            prev = bck_o;
        end
    endtask

    task automatic check_frame(input logic [1:0] code, input logic [23:0] l,
                               input logic [23:0] r, input logic [63:0] vdl,
                               input logic [63:0] vdln, input logic [63:0] vdr,
                               input logic [63:0] vdrn, input logic [63:0] vle);
        logic [63:0] edl, edr, edln, edrn, ele;
        string rq, rl, ri;
        case (kind(code))
            0: begin
                edl = {48'b0, ~l[23], l[22:8]};
                edr = {48'b0, ~r[23], r[22:8]};
                ele = 64'h0000_0000_8000_0000;
                rq = "R4"; rl = "R8"; ri = "R7";
            end
            2: begin
                edl = {40'b0, l};
                edr = {40'b0, r};
                ele = 64'h0000_0000_8000_0000;
                rq = "R5"; rl = "R8"; ri = "R7";
            end
            default: begin
                edl = '0;
                edr = {1'b0, l, 7'b0, 1'b0, r, 7'b0};
                ele = 64'h0000_0000_FFFF_FFFF;
                rq = "R6"; rl = "R6"; ri = "R6";
            end
        endcase
        if (kind(code) == 1) begin
            edln = '0; edrn = '0;
        end else begin
            edln = {32'b0, ~edl[31:0]};
            edrn = {32'b0, ~edr[31:0]};
        end
        check(rq, "left line", vdl, edl);
        check(rq, "right line", vdr, edr);
        check(rl, "latch/word select", vle, ele);
        check(ri, "inverted left", vdln, edln);
        check(ri, "inverted right", vdrn, edrn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, c, d, e;
        int n;
        int hi;
        int per;
        logic [23:0] kl;
        logic [23:0] kr;

        // R11: reset state; mode 0 is captured during reset (R3)
        mode_i = 2'd0;
        repeat (3) @(negedge clk);
        check("R11", "outputs in reset",
              {58'b0, ready_o, lews_o, dl_o, dln_o, dr_o, drn_o}, 64'd0);
        // R2: master clock forwarded
        @(posedge clk); #2;
        check("R2", "mck high phase", {63'b0, mck_o}, 64'd1);
        @(negedge clk); #1;
        check("R2", "mck low phase", {63'b0, mck_o}, 64'd0);
        rst_i = 1'b0;

        // R3: first boundary after reset in 16-bit split format
        n = 0;
        do begin @(negedge clk); n++; end while (!ready_o && n < 1000);
        check("R3", "cycles to first boundary", 64'(n), 64'(32*DIV-1));
        @(negedge clk);
        // R9: ready lasts one cycle
        check("R9", "ready single cycle", {63'b0, ready_o}, 64'd0);

        // R1: bit clock period and duty
        while (bck_o) @(negedge clk);
        while (!bck_o) @(negedge clk);
        hi = 0;
        while (bck_o) begin hi++; @(negedge clk); end
        per = hi;
        while (!bck_o) begin per++; @(negedge clk); end
        check("R1", "bck high cycles", 64'(hi), 64'(DIV/2));
        check("R1", "bck period", 64'(per), 64'(DIV));

        // Table walk: R3 R4 R5 R6 R7 R8 across formats and mode changes
        for (int i = 0; i < NV; i++) begin
            run_frame(TABLE[i][49:48], TABLE[i][47:24], TABLE[i][23:0], 1'b1,
                      a, b, c, d, e);
            check_frame(TABLE[i][49:48], TABLE[i][47:24], TABLE[i][23:0], a, b, c, d, e);
        end
        kl = TABLE[NV-1][47:24];
        kr = TABLE[NV-1][23:0];

        // R10: no valid -> last pair repeats
        run_frame(2'd2, 24'h111111, 24'h222222, 1'b0, a, b, c, d, e);
        check_frame(2'd2, kl, kr, a, b, c, d, e);

        // R9, R3: valid and a mode change away from the boundary are ignored
        while (ready_o) @(negedge clk);
        valid_i = 1'b1; left_i = 24'h333333; right_i = 24'h444444; mode_i = 2'd1;
        @(negedge clk);
        valid_i = 1'b0; mode_i = 2'd2;
        run_frame(2'd2, 24'h555555, 24'h666666, 1'b0, a, b, c, d, e);
        check_frame(2'd2, kl, kr, a, b, c, d, e);

        // R9: an accepted pair after that shows up
        run_frame(2'd1, 24'h7FFFFF, 24'h800000, 1'b1, a, b, c, d, e);
        check_frame(2'd1, 24'h7FFFFF, 24'h800000, a, b, c, d, e);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule